// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This unit carries out two related families of single-word bit operations on a 32-bit operand. The first family reads one bit selected by an offset into the carry flag. It can then leave the bit alone, clear it, set it or invert it, and it returns the resulting operand together with a write-enable. The second family is a bit scan in either direction. It reports through the zero flag whether any bit is set and, when one is, loads the position of the first set bit met into a destination index.

Each request is presented for one cycle with a valid strobe. The result appears on the registered outputs one clock later, marked by a one-cycle output valid pulse. The flags, the operand result and the index are architectural-style holding registers. An operation that does not define a value leaves it as it was, so an execution pipeline can read them at any time.

Top module: `bit_unit`

## Requirements
- R1: Operation code 0 (test) copies bit `offset` of the operand into `out_cf`, drives `out_value` with the operand unchanged, and keeps `out_wr` low.
- R2: Operation code 1 (test-and-reset) copies the selected bit into `out_cf`, drives `out_value` with that bit cleared, and raises `out_wr`.
- R3: Operation code 2 (test-and-set) copies the selected bit into `out_cf`, drives `out_value` with that bit set, and raises `out_wr`.
- R4: Operation code 3 (test-and-complement) copies the selected bit into `out_cf`, drives `out_value` with that bit inverted, and raises `out_wr`.
- R5: The bit offset is reduced modulo 32, so an offset of 35 selects bit 3 and an offset of 224 selects bit 0.
- R6: Operation code 4 (scan forward) on a non-zero operand clears `out_zf` and loads the index of the lowest set bit into `out_index`.
- R7: Operation code 5 (scan reverse) on a non-zero operand clears `out_zf` and loads the index of the highest set bit into `out_index`.
- R8: A scan of either direction on an all-zero operand sets `out_zf` and leaves `out_index` at its previous value.
- R9: The results of a request accepted with `in_valid` high appear one clock later, with `out_valid` high for exactly that cycle. With `in_valid` low, `out_valid` is low in the next cycle.
- R10: Scans leave `out_cf` and `out_value` unchanged and keep `out_wr` low. Bit tests leave `out_zf` and `out_index` unchanged.
- R11: Operation codes 6 and 7 still produce an `out_valid` pulse but change no flag, value or index, and keep `out_wr` low.
- R12: While `rst` is high, every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 test, 1 reset, 2 set, 3 complement, 4 scan forward, 5 scan reverse) |
| in_value | input | 32 | Operand |
| in_offset | input | 8 | Bit offset, taken modulo 32 |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_cf | output | 1 | Carry flag: the tested bit |
| out_zf | output | 1 | Zero flag: the scanned operand was all zeros |
| out_value | output | 32 | Operand after the bit operation |
| out_wr | output | 1 | Write-enable for `out_value` on modifying tests |
| out_index | output | 5 | Scan destination index |

## Verification
The hardest case to reach is the zero scan holding a meaningful index. The index must first be loaded with a distinctive non-zero value, and that value must then survive a zero-operand scan in each direction and a bit test that follows. The stimulus therefore loads index 23 with a reverse scan. It then issues zero scans and a test back to back, checking that the zero flag rises while the index stays at 23. Offset wrap-around is driven with offsets that have only high bits set, and the reserved codes are placed between operations that leave distinct flag values.

// File: rtl/bitscan_pkg.sv
package bitscan_pkg;

    typedef enum logic [2:0] {
        OP_TEST  = 3'd0,
        OP_RESET = 3'd1,
        OP_SET   = 3'd2,
        OP_FLIP  = 3'd3,
        OP_FWD   = 3'd4,
        OP_REV   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } bop_e;

    typedef struct packed {
        logic test;      // any bit-test form, including plain test
        logic modify;    // write-back forms only
        logic scan_fwd;
        logic scan_rev;
    } bclass_t;

    function automatic bclass_t decode_op(bop_e op);
        bclass_t c;
        c.test     = (op == OP_TEST) || (op == OP_RESET) ||
                     (op == OP_SET)  || (op == OP_FLIP);
        c.modify   = (op == OP_RESET) || (op == OP_SET) || (op == OP_FLIP);
        c.scan_fwd = (op == OP_FWD);
        c.scan_rev = (op == OP_REV);
        return c;
    endfunction

endpackage

// File: rtl/bit_modify.sv
module bit_modify
    import bitscan_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [IDX_W-1:0] idx,
    input  bop_e             op,
    output logic             bit_old,
    output logic [WIDTH-1:0] value_new
);
    logic [WIDTH-1:0] mask;

    always_comb begin
        mask    = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
        bit_old = value[idx];
        unique case (op)
            OP_RESET: value_new = value & ~mask;
            OP_SET:   value_new = value | mask;
            OP_FLIP:  value_new = value ^ mask;
            default:  value_new = value;
        endcase
    end
endmodule

// File: rtl/bit_scan.sv
module bit_scan #(
    parameter int WIDTH   = 32,
    parameter int IDX_W   = $clog2(WIDTH),
    parameter int REVERSE = 0
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    generate
        if (REVERSE != 0) begin : g_high_first
            always_comb begin
                idx = '0;
                for (int i = 0; i < WIDTH; i++) begin
                    if (vec[i]) idx = IDX_W'(i);
                end
            end
        end else begin : g_low_first
            always_comb begin
                idx = '0;
                for (int i = WIDTH - 1; i >= 0; i--) begin
                    if (vec[i]) idx = IDX_W'(i);
                end
            end
        end
    endgenerate

    assign found = |vec;
endmodule

// File: rtl/bit_unit.sv
module bit_unit
    import bitscan_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int OFFSET_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [2:0]               in_op,
    input  logic [WIDTH-1:0]         in_value,
    input  logic [OFFSET_W-1:0]      in_offset,
    output logic                     out_valid,
    output logic                     out_cf,
    output logic                     out_zf,
    output logic [WIDTH-1:0]         out_value,
    output logic                     out_wr,
    output logic [$clog2(WIDTH)-1:0] out_index
);
    localparam int IDX_W  = $clog2(WIDTH);
    localparam int NSCAN  = 2;

    bop_e             op;
    bclass_t          cls;
    logic [IDX_W-1:0] ofs_mod;
    logic             bit_old;
    logic [WIDTH-1:0] value_new;
    logic             scan_found [NSCAN];
    logic [IDX_W-1:0] scan_idx   [NSCAN];

    always_comb begin
        op      = bop_e'(in_op);
        cls     = decode_op(op);
        ofs_mod = IDX_W'(in_offset % OFFSET_W'(WIDTH));
    end

    bit_modify #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_modify (
        .value     (in_value),
        .idx       (ofs_mod),
        .op        (op),
        .bit_old   (bit_old),
        .value_new (value_new)
    );

    generate
        for (genvar g = 0; g < NSCAN; g++) begin : g_scan
            bit_scan #(.WIDTH(WIDTH), .IDX_W(IDX_W), .REVERSE(g)) u_scan (
                .vec   (in_value),
                .found (scan_found[g]),
                .idx   (scan_idx[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_cf    <= 1'b0;
            out_zf    <= 1'b0;
            out_value <= '0;
            out_wr    <= 1'b0;
            out_index <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr    <= in_valid && cls.modify;
            if (in_valid && cls.test) begin
                out_cf    <= bit_old;
                out_value <= value_new;
            end
            if (in_valid && cls.scan_fwd) begin
                out_zf <= !scan_found[0];
                if (scan_found[0]) out_index <= scan_idx[0];
            end
            if (in_valid && cls.scan_rev) begin
                out_zf <= !scan_found[1];
                if (scan_found[1]) out_index <= scan_idx[1];
            end
        end
    end
endmodule

// File: rtl/bit_unit_chk.sv
module bit_unit_chk #(
    parameter int WIDTH    = 32,
    parameter int OFFSET_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [2:0]               in_op,
    input logic [WIDTH-1:0]         in_value,
    input logic [OFFSET_W-1:0]      in_offset,
    input logic                     out_valid,
    input logic                     out_cf,
    input logic                     out_zf,
    input logic [WIDTH-1:0]         out_value,
    input logic                     out_wr,
    input logic [$clog2(WIDTH)-1:0] out_index
);
    localparam int IDX_W = $clog2(WIDTH);
    logic [IDX_W-1:0] sel;
    assign sel = IDX_W'(in_offset % WIDTH);

    // R9
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R1
    test_copies_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op) == 3'd0) |->
            (out_cf == $past(in_value[sel]) && !out_wr && out_value == $past(in_value)));

    // R4
    flip_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op) == 3'd3) |->
            ($countones(out_value ^ $past(in_value)) == 1 && out_wr));

    // R6
    fwd_hits_set_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op) == 3'd4 && !out_zf) |->
            ((($past(in_value) >> out_index) & 1) == 1));

    // R7
    rev_hits_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op) == 3'd5 && !out_zf) |->
            (($past(in_value) >> out_index) == 1));

    // R8
    zero_scan_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_op) == 3'd4 || $past(in_op) == 3'd5) && out_zf) |->
            ($stable(out_index) && $past(in_value) == '0));

    // R10
    scan_keeps_cf_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op) >= 3'd4) |->
            ($stable(out_cf) && $stable(out_value) && !out_wr));
endmodule

bind bit_unit bit_unit_chk #(.WIDTH(WIDTH), .OFFSET_W(OFFSET_W)) u_chk (.*);

// File: tb/bit_unit_test.sv
`timescale 1ns/1ps
module bit_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_value = '0;
    logic [7:0]  in_offset = '0;
    logic        out_valid, out_cf, out_zf, out_wr;
    logic [31:0] out_value;
    logic [4:0]  out_index;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic        cf;
        logic        zf;
        logic        wr;
        logic [31:0] value;
        logic [4:0]  index;
        string       tag;
    } exp_t;

    exp_t q[$];

    // bench-side architectural state
    logic        m_cf = 0, m_zf = 0;
    logic [31:0] m_value = '0;
    logic [4:0]  m_index = '0;

    always #2 clk = ~clk;

    bit_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_value(in_value), .in_offset(in_offset), .out_valid(out_valid),
        .out_cf(out_cf), .out_zf(out_zf), .out_value(out_value),
        .out_wr(out_wr), .out_index(out_index)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] v,
                         input logic [7:0] o, input string tag);
        exp_t e;
        int   b;
        logic wr;
        @(negedge clk);
        in_valid  = 1'b1;
        in_op     = op;
        in_value  = v;
        in_offset = o;
        b  = o % 32;
        wr = 1'b0;
        case (op)
            3'd0: begin m_cf = v[b]; m_value = v; end
            3'd1: begin m_cf = v[b]; m_value = v; m_value[b] = 1'b0; wr = 1; end
            3'd2: begin m_cf = v[b]; m_value = v; m_value[b] = 1'b1; wr = 1; end
            3'd3: begin m_cf = v[b]; m_value = v; m_value[b] = ~v[b]; wr = 1; end
            3'd4: begin
                m_zf = (v == 0);
                for (int i = 31; i >= 0; i--) if (v[i]) m_index = 5'(i);
            end
            3'd5: begin
                m_zf = (v == 0);
                for (int i = 0; i < 32; i++) if (v[i]) m_index = 5'(i);
            end
            default: ;
        endcase
        e.cf = m_cf; e.zf = m_zf; e.wr = wr; e.value = m_value;
        e.index = m_index; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(0, "R9 unexpected out_valid", "1", "0");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(out_cf == e.cf && out_zf == e.zf && out_wr == e.wr &&
                      out_value == e.value && out_index == e.index, e.tag,
                      $sformatf("cf=%0b zf=%0b wr=%0b val=%08h idx=%0d",
                                out_cf, out_zf, out_wr, out_value, out_index),
                      $sformatf("cf=%0b zf=%0b wr=%0b val=%08h idx=%0d",
                                e.cf, e.zf, e.wr, e.value, e.index));
            end
        end
    end

    initial begin
        #(200000 * 4);
        check(0, "watchdog", "timeout", "finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_cf && !out_zf && !out_wr && out_value == 0 &&
              out_index == 0, "R12 reset state",
              $sformatf("%0b%0b%0b%0b %08h %0d", out_valid, out_cf, out_zf, out_wr,
                        out_value, out_index), "0000 00000000 0");
        @(negedge clk);
        rst = 1'b0;

        drive(3'd0, 32'h0000_0010, 8'd4,  "R1 test set bit");
        drive(3'd0, 32'h0000_0010, 8'd5,  "R1 test clear bit");
        drive(3'd1, 32'hFFFF_FFFF, 8'd31, "R2 reset top bit");
        drive(3'd1, 32'h0000_0000, 8'd7,  "R2 reset already clear");
        drive(3'd2, 32'h0000_0000, 8'd0,  "R3 set bit 0");
        drive(3'd2, 32'h8000_0000, 8'd31, "R3 set already set");
        drive(3'd3, 32'hA5A5_A5A5, 8'd2,  "R4 complement bit 2");
        drive(3'd3, 32'h0000_0008, 8'd35, "R5 offset 35 is bit 3");
        drive(3'd2, 32'h0000_0002, 8'd224,"R5 offset 224 is bit 0");
        drive(3'd4, 32'h0001_8000, 8'd0,  "R6 forward lowest");
        drive(3'd5, 32'h0001_8000, 8'd0,  "R7 reverse highest");
        drive(3'd4, 32'h8000_0000, 8'd0,  "R6 forward only top");
        drive(3'd5, 32'h0000_0001, 8'd0,  "R7 reverse only bottom");
        drive(3'd5, 32'h00F0_0000, 8'd0,  "R7 reverse load 23");
        drive(3'd4, 32'h0000_0000, 8'd0,  "R8 forward zero holds index");
        drive(3'd5, 32'h0000_0000, 8'd0,  "R8 reverse zero holds index");
        drive(3'd0, 32'h0000_0001, 8'd0,  "R10 test keeps zf and index");
        drive(3'd4, 32'h0000_0100, 8'd0,  "R10 scan keeps cf and value");
        drive(3'd6, 32'hFFFF_FFFF, 8'd1,  "R11 code 6 no change");
        drive(3'd7, 32'h0000_0000, 8'd9,  "R11 code 7 no change");
        idle(1);
        @(posedge clk);
        #1;
        check(!out_valid, "R9 no request no valid", $sformatf("%0b", out_valid), "0");
        drive(3'd3, 32'h0000_0000, 8'd16, "R9 after idle");
        idle(3);
        check(q.size() == 0, "R9 all results seen", $sformatf("%0d", q.size()), "0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule